// File: doc/BRIEF.md
# Not-Recently-Used Page Victim Selector

This block keeps two status bits for each page frame of a small fixed pool: a "touched" bit that records any access since the last interval clear, and a "dirty" bit that records a write since the frame was last filled. A programmable interval timer wipes every touched bit at once. Dirty bits survive that wipe. When the memory manager needs room, it raises a victim request. Two clock edges later the block answers with the index of a frame that is cheapest to evict.

Frames are ranked into four classes by the two-bit code {touched, dirty}. The answer always comes from the lowest-numbered class that holds at least one frame. A free-running LFSR sets a rotating start point for a priority search inside the winning class. The choice among equal candidates is therefore spread over the class and does not favour low indices. A fill port marks a frame as freshly loaded, which makes it touched and clean.

Top module: `nru_victim_selector`

## Requirements
- R1: An access (acc_valid high) to frame F sets F's touched bit at that clock edge. This holds even when an interval clear happens at the same edge.
- R2: An access with acc_write high also sets F's dirty bit. A read access leaves the dirty bit unchanged.
- R3: An interval clear drops the touched bit of every frame not accessed or loaded at that edge, all at the same edge. It leaves all dirty bits unchanged, so class 1 (untouched but dirty) can arise and is ranked like any other class.
- R4: After a write of cfg_interval with cfg_wr high, the clear fires at every P-th edge (P = the written value). The first clear comes P edges after the write edge. A write restarts the count. P = 0 stops all clears.
- R5: The class of a frame is the code {touched, dirty}: 0 = untouched clean, 1 = untouched dirty, 2 = touched clean, 3 = touched dirty. The returned frame belongs to the lowest class that has at least one member, judged on the bits held just before the request edge.
- R6: A load (load_valid high) of frame F makes F touched and clean at that edge. The load wins over an access to F and over an interval clear in the same cycle.
- R7: A request sampled at edge k gives vic_valid high for exactly the one cycle after edge k+1, with vic_frame valid in that cycle. Each request gets its own answer, including back-to-back requests. vic_valid is low in every other cycle.
- R8: When many frames share the lowest class, repeated requests return several different frames of that class.
- R9: Reset clears every touched and dirty bit, restarts the interval count and loads the interval from the INIT_INTERVAL parameter (default 0, meaning no clears). vic_valid is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe for the frame on acc_frame |
| acc_frame | input | 4 | Index of the accessed frame |
| acc_write | input | 1 | Access is a write |
| load_valid | input | 1 | Fill strobe for the frame on load_frame |
| load_frame | input | 4 | Index of the filled frame |
| cfg_wr | input | 1 | Writes cfg_interval and restarts the timer |
| cfg_interval | input | 16 | Clear period in clock cycles; 0 disables |
| vic_req | input | 1 | Victim request |
| vic_valid | output | 1 | Victim answer strobe |
| vic_frame | output | 4 | Chosen victim frame |

## Verification
The assertions assume that acc_frame and load_frame always name an existing frame. They also assume that a request is never raised during reset, so the two-edge answer check never looks back into reset cycles. The stimulus draws frame indices only from the legal range and keeps vic_req low until reset is released. It does drive every mix of access, write, load, clear and request in the same cycle. Because the within-class choice is random, the bench checks membership in the lowest non-empty class rather than an exact index, and checks for spread separately.

// File: rtl/nru_pkg.sv
package nru_pkg;

  localparam int unsigned CLASS_W = 2;
  localparam int unsigned NUM_CLASSES = 4;

  // Class code is {touched, dirty}; lower means cheaper to evict.
  typedef enum logic [CLASS_W-1:0] {
    CLS_COLD_CLEAN = 2'd0,
    CLS_COLD_DIRTY = 2'd1,
    CLS_HOT_CLEAN  = 2'd2,
    CLS_HOT_DIRTY  = 2'd3
  } frame_class_e;

  function automatic frame_class_e frame_class(input logic touched, input logic dirty);
    return frame_class_e'({touched, dirty});
  endfunction

  // One step of a 16-bit Galois LFSR (maximal length taps).
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

endpackage

// File: rtl/nru_interval_timer.sv
module nru_interval_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INIT_INTERVAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_value,
  output logic             tick
);

  localparam logic [CNT_W-1:0] INIT_P = CNT_W'(INIT_INTERVAL);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] count_q;
  logic             period_on;
  logic             at_end;

  assign period_on = (period_q != '0);
  assign at_end    = (count_q == (period_q - ONE));
  assign tick      = period_on && at_end && !cfg_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= INIT_P;
      count_q  <= '0;
    end else if (cfg_wr) begin
      period_q <= cfg_value;
      count_q  <= '0;
    end else if (!period_on || tick) begin
      count_q  <= '0;
    end else begin
      count_q  <= count_q + ONE;
    end
  end

  // R4: a zero period never produces a clear
  a_r4_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0) |-> !tick);

  // R4: count stays inside the programmed period
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    period_on |-> (count_q < period_q));

  // R4: a configuration write restarts the count
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (count_q == '0));

endmodule

// File: rtl/nru_frame_state.sv
module nru_frame_state #(
  parameter int unsigned N_FRAMES = 16,
  parameter int unsigned IDX_W = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [IDX_W-1:0]    acc_idx,
  input  logic                acc_write,
  input  logic                load_valid,
  input  logic [IDX_W-1:0]    load_idx,
  input  logic                clear_ref,
  output logic [N_FRAMES-1:0] touched_o,
  output logic [N_FRAMES-1:0] dirty_o
);

  logic [N_FRAMES-1:0] touched_q, dirty_q;
  logic [N_FRAMES-1:0] touched_d, dirty_d;
  logic [N_FRAMES-1:0] acc_hit, load_hit;

  // One-hot decode of the two ports, one slice per frame.
  for (genvar g = 0; g < N_FRAMES; g++) begin : g_decode
    assign acc_hit[g]  = acc_valid  && (acc_idx  == IDX_W'(g));
    assign load_hit[g] = load_valid && (load_idx == IDX_W'(g));
  end

  always_comb begin
    for (int i = 0; i < N_FRAMES; i++) begin
      if (load_hit[i]) begin
        touched_d[i] = 1'b1;
        dirty_d[i]   = 1'b0;
      end else begin
        touched_d[i] = acc_hit[i] ? 1'b1 : (clear_ref ? 1'b0 : touched_q[i]);
        dirty_d[i]   = dirty_q[i] | (acc_hit[i] & acc_write);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      touched_q <= '0;
      dirty_q   <= '0;
    end else begin
      touched_q <= touched_d;
      dirty_q   <= dirty_d;
    end
  end

  assign touched_o = touched_q;
  assign dirty_o   = dirty_q;

  // R1: an access not overridden by a load leaves the frame touched
  a_r1_access_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !(load_valid && load_idx == acc_idx)) |=> touched_q[$past(acc_idx)]);

  // R2: a write access leaves the frame dirty
  a_r2_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !(load_valid && load_idx == acc_idx)) |=> dirty_q[$past(acc_idx)]);

  // R3: a quiet clear empties every touched bit
  a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_ref && !acc_valid && !load_valid) |=> (touched_q == '0));

  // R3: dirty bits survive a clear
  a_r3_keep_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_ref && !acc_valid && !load_valid) |=> $stable(dirty_q));

  // R6: a loaded frame is touched and clean
  a_r6_load_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> (touched_q[$past(load_idx)] && !dirty_q[$past(load_idx)]));

endmodule

// File: rtl/nru_victim_picker.sv
module nru_victim_picker
  import nru_pkg::*;
#(
  parameter int unsigned N_FRAMES = 16,
  parameter int unsigned IDX_W = $clog2(N_FRAMES),
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [N_FRAMES-1:0] touched_i,
  input  logic [N_FRAMES-1:0] dirty_i,
  output logic                valid_o,
  output logic [IDX_W-1:0]    idx_o
);

  // First set bit at or after 'start', wrapping round the frame ring.
  function automatic logic [IDX_W-1:0] rot_pick(input logic [N_FRAMES-1:0] mask,
                                                 input logic [IDX_W-1:0] start);
    logic [IDX_W-1:0] res;
    logic found;
    res = start;
    found = 1'b0;
    for (int k = 0; k < N_FRAMES; k++) begin
      int j;
      j = (int'(start) + k) % N_FRAMES;
      if (!found && mask[j]) begin
        res = IDX_W'(j);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  logic [15:0]         lfsr_q;
  logic [N_FRAMES-1:0] cls_mask [NUM_CLASSES];
  logic [N_FRAMES-1:0] win_mask;
  logic [IDX_W-1:0]    start_pt;

  logic                s1_valid;
  logic [N_FRAMES-1:0] s1_mask;
  logic [IDX_W-1:0]    s1_start;
  logic [IDX_W-1:0]    pick_idx;

  // Membership mask of each class.
  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    always_comb begin
      for (int i = 0; i < N_FRAMES; i++) begin
        cls_mask[c][i] = (frame_class(touched_i[i], dirty_i[i]) == frame_class_e'(c));
      end
    end
  end

  // Lowest non-empty class wins.
  always_comb begin
    win_mask = cls_mask[NUM_CLASSES-1];
    for (int c = NUM_CLASSES - 2; c >= 0; c--) begin
      if (cls_mask[c] != '0) win_mask = cls_mask[c];
    end
  end

  assign start_pt = IDX_W'(lfsr_q % 16'(N_FRAMES));
  assign pick_idx = rot_pick(s1_mask, s1_start);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q   <= LFSR_SEED;
      s1_valid <= 1'b0;
      s1_mask  <= '0;
      s1_start <= '0;
      valid_o  <= 1'b0;
      idx_o    <= '0;
    end else begin
      lfsr_q   <= lfsr_step(lfsr_q);
      s1_valid <= req;
      if (req) begin
        s1_mask  <= win_mask;
        s1_start <= start_pt;
      end
      valid_o  <= s1_valid;
      if (s1_valid) idx_o <= pick_idx;
    end
  end

  // R5: the snapshot of the winning class is never empty
  a_r5_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (s1_mask != '0));

  // R5: the search lands on a member of the winning class
  a_r5_member: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> s1_mask[pick_idx]);

  // R7: answer strobe follows the request by exactly two edges
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == $past(req, 2));

  // LFSR never locks up at zero
  a_r8_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/nru_victim_selector.sv
module nru_victim_selector #(
  parameter int unsigned N_FRAMES = 16,
  parameter int unsigned INTERVAL_W = 16,
  parameter int unsigned INIT_INTERVAL = 0,
  parameter int unsigned IDX_W = $clog2(N_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_frame,
  input  logic                  acc_write,
  input  logic                  load_valid,
  input  logic [IDX_W-1:0]      load_frame,
  input  logic                  cfg_wr,
  input  logic [INTERVAL_W-1:0] cfg_interval,
  input  logic                  vic_req,
  output logic                  vic_valid,
  output logic [IDX_W-1:0]      vic_frame
);

  logic                clear_tick;
  logic [N_FRAMES-1:0] touched;
  logic [N_FRAMES-1:0] dirty;

  nru_interval_timer #(
    .CNT_W(INTERVAL_W),
    .INIT_INTERVAL(INIT_INTERVAL)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_value(cfg_interval),
    .tick     (clear_tick)
  );

  nru_frame_state #(
    .N_FRAMES(N_FRAMES),
    .IDX_W(IDX_W)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_idx   (acc_frame),
    .acc_write (acc_write),
    .load_valid(load_valid),
    .load_idx  (load_frame),
    .clear_ref (clear_tick),
    .touched_o (touched),
    .dirty_o   (dirty)
  );

  nru_victim_picker #(
    .N_FRAMES(N_FRAMES),
    .IDX_W(IDX_W)
  ) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (vic_req),
    .touched_i(touched),
    .dirty_i  (dirty),
    .valid_o  (vic_valid),
    .idx_o    (vic_frame)
  );

  // R9: no answer leaves the block while reset is held
  a_r9_quiet_reset: assert property (@(posedge clk)
    !rst_n |=> !vic_valid);

endmodule

// File: tb/tb_nru_victim_selector.sv
module tb_nru_victim_selector;

  localparam int NF = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [3:0]  acc_frame = '0;
  logic        acc_write = 1'b0;
  logic        load_valid = 1'b0;
  logic [3:0]  load_frame = '0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_interval = '0;
  logic        vic_req = 1'b0;
  logic        vic_valid;
  logic [3:0]  vic_frame;

  nru_victim_selector dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .load_valid(load_valid), .load_frame(load_frame),
    .cfg_wr(cfg_wr), .cfg_interval(cfg_interval),
    .vic_req(vic_req), .vic_valid(vic_valid), .vic_frame(vic_frame)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  string phase = "reset";
  logic  collect = 1'b0;
  logic [NF-1:0] seen = '0;
  bit done = 1'b0;

  // Bench model of the bookkeeping.
  logic [NF-1:0] m_t = '0, m_d = '0;
  logic [15:0]   m_per = '0, m_cnt = '0;
  logic          ev1 = 1'b0, ev2 = 1'b0;
  logic [NF-1:0] em1 = '0, em2 = '0;

  // Frames of the cheapest class present: {touched,dirty} as a number.
  function automatic logic [NF-1:0] cheapest(input logic [NF-1:0] t, input logic [NF-1:0] d);
    for (int cls = 0; cls < 4; cls++) begin
      logic [NF-1:0] m;
      m = '0;
      for (int f = 0; f < NF; f++) if ((2 * int'(t[f]) + int'(d[f])) == cls) m[f] = 1'b1;
      if (m != '0) return m;
    end
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t <= '0; m_d <= '0; m_per <= '0; m_cnt <= '0;
      ev1 <= 1'b0; ev2 <= 1'b0; em1 <= '0; em2 <= '0;
    end else begin
      logic clr;
      logic [NF-1:0] nt, nd;
      clr = !cfg_wr && (m_per != 0) && (m_cnt + 16'd1 == m_per);
      if (cfg_wr) begin m_per <= cfg_interval; m_cnt <= '0; end
      else if (m_per == 0 || clr) m_cnt <= '0;
      else m_cnt <= m_cnt + 16'd1;
      nt = clr ? '0 : m_t;
      nd = m_d;
      if (acc_valid) begin
        nt[acc_frame] = 1'b1;
        if (acc_write) nd[acc_frame] = 1'b1;
      end
      if (load_valid) begin nt[load_frame] = 1'b1; nd[load_frame] = 1'b0; end
      em1 <= cheapest(m_t, m_d);
      ev1 <= vic_req;
      em2 <= em1;
      ev2 <= ev1;
      m_t <= nt;
      m_d <= nd;
    end
  end

  // Answer checker, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done && (ev2 || vic_valid)) begin
      checks++;
      if (vic_valid !== ev2) begin
        failures++;
        $display("FAIL R7 [%s] vic_valid=%0b expected=%0b", phase, vic_valid, ev2);
      end else if (!em2[vic_frame]) begin
        failures++;
        $display("FAIL R5 [%s] vic_frame=%0d expected one of mask %h", phase, vic_frame, em2);
      end
      if (collect) seen[vic_frame] = 1'b1;
    end
  end

  task automatic step();
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; load_valid = 1'b0; cfg_wr = 1'b0; vic_req = 1'b0;
  endtask

  task automatic access(input int f, input bit w);
    acc_valid = 1'b1; acc_frame = 4'(f); acc_write = w; step();
  endtask

  task automatic set_interval(input int v);
    cfg_wr = 1'b1; cfg_interval = 16'(v); step();
  endtask

  task automatic requests(input int n);
    for (int i = 0; i < n; i++) begin vic_req = 1'b1; step(); end
    repeat (3) step();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R9: nothing answers while in reset
    checks++;
    if (vic_valid !== 1'b0) begin
      failures++; $display("FAIL R9 vic_valid=%0b expected=0", vic_valid);
    end
    rst_n = 1'b1;
    step();

    // R8: all frames class 0, answers should spread
    phase = "R8 spread";
    collect = 1'b1;
    requests(64);
    collect = 1'b0;
    checks++;
    if ($countones(seen) < 4) begin
      failures++; $display("FAIL R8 distinct=%0d expected>=4", $countones(seen));
    end

    // R1 / R5: every frame read except 9 -> 9 is the only cold frame
    phase = "R1 R5 read";
    for (int f = 0; f < NF; f++) if (f != 9) access(f, 1'b0);
    requests(4);
    // R2: write 9 -> class 3, others class 2
    phase = "R2 write";
    access(9, 1'b1);
    requests(4);

    // R9: dirty frame 5, then reset; afterwards only 5 is left untouched
    phase = "R9 reset clears";
    access(5, 1'b1);
    rst_n = 1'b0; step(); step();
    rst_n = 1'b1; step();
    for (int f = 0; f < NF; f++) if (f != 5) access(f, 1'b0);
    requests(4);

    // R3: write all but 2, read 2, then let the clear fire -> class 1 appears
    phase = "R3 clear";
    for (int f = 0; f < NF; f++) access(f, f != 2);
    set_interval(30);
    repeat (35) step();
    requests(4);
    phase = "R3 class1";
    access(2, 1'b0);
    requests(3);

    // R4: zero disables the clear; frame 3 stays the only cold frame
    phase = "R4 disabled";
    set_interval(0);
    for (int f = 0; f < NF; f++) if (f != 3) access(f, 1'b0);
    repeat (100) step();
    requests(8);

    // R6: all dirty, then load 7 with a write to 7 in the same cycle
    phase = "R6 load";
    for (int f = 0; f < NF; f++) access(f, 1'b1);
    load_valid = 1'b1; load_frame = 4'd7; acc_valid = 1'b1; acc_frame = 4'd7; acc_write = 1'b1;
    step();
    requests(3);
    // R6: load against a clear in the same cycle (period 1 clears every edge)
    set_interval(1);
    load_valid = 1'b1; load_frame = 4'd11; vic_req = 1'b1; step();
    vic_req = 1'b1; step();
    repeat (3) step();

    // R1 R2 R3 R4 R6 mixed: random traffic under changing intervals
    phase = "random mix";
    for (int i = 0; i < 4000; i++) begin
      acc_valid  = ($urandom_range(1, 0) == 1);
      acc_frame  = 4'($urandom_range(NF - 1, 0));
      acc_write  = ($urandom_range(2, 0) == 0);
      load_valid = ($urandom_range(7, 0) == 0);
      load_frame = 4'($urandom_range(NF - 1, 0));
      vic_req    = ($urandom_range(3, 0) == 0);
      if ($urandom_range(199, 0) == 0) begin
        cfg_wr = 1'b1;
        cfg_interval = ($urandom_range(4, 0) == 0) ? 16'd0 : 16'($urandom_range(40, 1));
      end
      step();
    end
    repeat (4) step();
    finish_run();
  end

endmodule